// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects an internal single-word request port to an external 128K×8 asynchronous static RAM. A client offers one request at a time on a valid/ready handshake: a read or a write, with its address and write data. The controller turns each request into pin-level activity on the RAM. That activity is a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable and the driver enable for the shared 8-bit data bus. For a read, the controller returns the captured byte with a single-cycle valid pulse.

Every analog timing limit of the RAM becomes a clock-cycle count. Each count is worked out at elaboration from a nanosecond parameter and the clock frequency, as ceil(ns × MHz / 1000) with a floor of one cycle.

The write pulse is stretched so that it covers three limits:
- the nominal write pulse;
- the RAM's output turn-off time plus the data setup time;
- the address-valid-to-end-of-write time.

After every read, a turnaround interval lets the RAM release the bus before the controller may drive it again. Between requests the RAM sits deselected in standby.

Top module: `asramCtrl`

## Requirements
- R1: During and after reset, and whenever `reqReady` is high, the pins show standby: `memCe1N`=1, `memCe2`=0, `memOeN`=1, `memWeN`=1 and `memDqOe`=0.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is low in the cycle after acceptance. While `reqValid` is low, changes on `reqWrite`, `reqAddr` and `reqWdata` leave the pins in standby.
- R3: While `memWeN` is low, `memAddr` and `memDqOut` do not change.
- R4: The timing of a write follows these rules:
  - `memWeN` goes low only while the RAM is selected, `memOeN` is high and `memDqOe` is high.
  - It stays low for exactly WP cycles, where WP = max(cyc(40 ns), cyc(20+25 ns), cyc(50 ns)−1), which is 6 at 125 MHz.
  - The data driver is still on in the cycle after `memWeN` rises.
- R5: For a read, the RAM is selected with `memOeN` low and `memWeN` high for AA = max(2, cyc(55 ns)) cycles, which is 7 at 125 MHz. `rdValid` is high for exactly one cycle, AA clock edges after the accepting edge.
- R6: After `memOeN` rises, `memDqOe` does not rise until more than TURN = cyc(30 ns) cycles have passed, which is 4 at 125 MHz.
- R7: `memDqOe` is never high while `memOeN` is low.
- R8: `rdData` holds the byte most recently written to the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqWdata | input | DATA_W | Byte to write |
| rdValid | output | 1 | One-cycle pulse, rdData valid |
| rdData | output | DATA_W | Byte captured from the RAM |
| memAddr | output | ADDR_W | RAM address pins |
| memCe1N | output | 1 | RAM chip select, active low |
| memCe2 | output | 1 | RAM chip select, active high |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDqOut | output | DATA_W | Data toward the RAM |
| memDqOe | output | 1 | Drive enable for memDqOut onto the shared bus |
| memDqIn | input | DATA_W | Data from the shared bus |

## Verification
A state machine stuck in or skipping a read state shows at the ports within one request: `rdValid` arrives at the wrong edge, or `rdData` carries data the RAM model only presents once the full access time has elapsed. A shortened or skipped turnaround shows in the first write after a read, because the driver enable rises while the model RAM is still driving. A wrong write-count load shows at the first write, as a write-enable pulse of the wrong width. A miswired address register shows at the next read-back, since every location of a small configuration is written and read with distinct patterns, in both directions and in pseudo-random order.

// File: rtl/asramCtrlPkg.sv
`timescale 1ns/1ps
package asramCtrlPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_SETUP, S_RD_WAIT, S_RD_CAPTURE,
    S_WR_SETUP, S_WR_PULSE, S_WR_HOLD, S_TURN
  } ctrlState_e;

  // Strobes from control to datapath. The first four are registered pin levels;
  // capture and load are single-cycle enables.
  typedef struct packed {
    logic sel;
    logic outEn;
    logic wrEn;
    logic busDrv;
    logic capture;
    logic load;
  } ctrlStrobe_t;

  function automatic int nsToCycles(input int ns, input int clkMhz);
    int c;
    c = (ns * clkMhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asramCtrlFsm.sv
`timescale 1ns/1ps
module asramCtrlFsm
  import asramCtrlPkg::*;
#(
  parameter int AA_CYC   = 7,
  parameter int WP_CYC   = 6,
  parameter int TURN_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strb
);

  localparam int CNT_MAX = maxOf(maxOf(AA_CYC, WP_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [3:0] pinReg;

  // Pin levels per state: {sel, outEn, wrEn, busDrv}
  function automatic logic [3:0] pinsFor(input ctrlState_e s);
    case (s)
      S_RD_SETUP, S_RD_WAIT: return 4'b1100;
      S_WR_SETUP:            return 4'b1001;
      S_WR_PULSE:            return 4'b1011;
      S_WR_HOLD:             return 4'b0001;
      default:               return 4'b0000;
    endcase
  endfunction

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      S_IDLE:
        if (reqValid) stateNext = reqWrite ? S_WR_SETUP : S_RD_SETUP;
      S_RD_SETUP: begin
        stateNext = S_RD_WAIT;
        cntNext   = CNT_W'(AA_CYC - 2);
      end
      S_RD_WAIT:
        if (cnt == '0) stateNext = S_RD_CAPTURE;
        else           cntNext   = cnt - 1'b1;
      S_RD_CAPTURE: begin
        stateNext = S_TURN;
        cntNext   = CNT_W'(TURN_CYC - 1);
      end
      S_TURN:
        if (cnt == '0) stateNext = S_IDLE;
        else           cntNext   = cnt - 1'b1;
      S_WR_SETUP: begin
        stateNext = S_WR_PULSE;
        cntNext   = CNT_W'(WP_CYC - 1);
      end
      S_WR_PULSE:
        if (cnt == '0) stateNext = S_WR_HOLD;
        else           cntNext   = cnt - 1'b1;
      S_WR_HOLD:  stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      pinReg <= pinsFor(S_IDLE);
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      pinReg <= pinsFor(stateNext);
    end
  end

  assign reqReady     = (state == S_IDLE);
  assign strb.sel     = pinReg[3];
  assign strb.outEn   = pinReg[2];
  assign strb.wrEn    = pinReg[1];
  assign strb.busDrv  = pinReg[0];
  assign strb.capture = (state == S_RD_WAIT) && (cnt == '0);
  assign strb.load    = reqReady && reqValid;

  // R1: idle means deselected, no write, bus released
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!strb.sel && !strb.wrEn && !strb.busDrv && !strb.outEn));

  // R5: capture enable is a single cycle
  a_r5_capture_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);

  // R2: after acceptance the controller is busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !reqReady);

endmodule

// File: rtl/asramCtrlDp.sv
`timescale 1ns/1ps
module asramCtrlDp
  import asramCtrlPkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int WP_CYC   = 6,
  parameter int TURN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  // Address and write data load only on acceptance, while the RAM is deselected
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (strb.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= memDqIn;
    end
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;
  assign memCe1N  = ~strb.sel;
  assign memCe2   = strb.sel;
  assign memOeN   = ~strb.outEn;
  assign memWeN   = ~strb.wrEn;
  assign memDqOe  = strb.busDrv;

  // Checker counters: width of the write pulse, cycles since output enable rose
  localparam int WL_W   = $clog2(WP_CYC + 2);
  localparam int OH_MAX = TURN_CYC + 2;
  localparam int OH_W   = $clog2(OH_MAX + 1);
  logic [WL_W-1:0] weLowRun;
  logic [OH_W-1:0] oeHighRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowRun  <= '0;
      oeHighRun <= OH_W'(OH_MAX);
    end else begin
      if (!memWeN) begin
        if (weLowRun != '1) weLowRun <= weLowRun + 1'b1;
      end else begin
        weLowRun <= '0;
      end
      if (memOeN) begin
        if (oeHighRun < OH_W'(OH_MAX)) oeHighRun <= oeHighRun + 1'b1;
      end else begin
        oeHighRun <= '0;
      end
    end
  end

  a_r3_hold_during_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> ($stable(memAddr) && $stable(memDqOut)));

  a_r4_write_qualified: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2 && memOeN && memDqOe));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowRun == WL_W'(WP_CYC)));

  a_r4_data_after_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDqOe);

  a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (oeHighRun > OH_W'(TURN_CYC)));

  a_r7_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

endmodule

// File: rtl/asramCtrl.sv
`timescale 1ns/1ps
module asramCtrl
  import asramCtrlPkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_MHZ   = 125,
  parameter int T_AA_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_AW_NS   = 50,
  parameter int T_WHZ_NS  = 20,
  parameter int T_DW_NS   = 25,
  parameter int T_OHZ_NS  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int AA_CYC   = maxOf(2, nsToCycles(T_AA_NS, CLK_MHZ));
  localparam int WP_CYC   = maxOf(maxOf(nsToCycles(T_WP_NS, CLK_MHZ),
                                        nsToCycles(T_WHZ_NS + T_DW_NS, CLK_MHZ)),
                                  maxOf(1, nsToCycles(T_AW_NS, CLK_MHZ) - 1));
  localparam int TURN_CYC = nsToCycles(T_OHZ_NS, CLK_MHZ);

  ctrlStrobe_t strb;

  asramCtrlFsm #(
    .AA_CYC  (AA_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asramCtrlDp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCe1N (memCe1N),
    .memCe2  (memCe2),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: tb/asramCtrl_tb.sv
`timescale 1ns/1ps
module asramCtrl_tb;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 125 + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_AA   = (cyc(55) < 2) ? 2 : cyc(55);
  localparam int EXP_WP0  = (cyc(40) > cyc(45)) ? cyc(40) : cyc(45);
  localparam int EXP_WP   = (EXP_WP0 > cyc(50) - 1) ? EXP_WP0 : cyc(50) - 1;
  localparam int EXP_TURN = cyc(30);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rdValid, memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [DATA_W-1:0] rdData, memDqOut;
  logic [DATA_W-1:0] memDqIn = '0;
  logic [ADDR_W-1:0] memAddr;

  asramCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkStandby(input string req);
    check(memCe1N && !memCe2 && memOeN && memWeN && !memDqOe, req,
          int'({memCe1N, memCe2, memOeN, memWeN, memDqOe}), 5'b10110);
  endtask

  // Behavioural RAM: access delay, output turn-off lag, write window checks
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];
  int rdCnt = 0, holdCnt = 0, wrLen = 0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic sel   = !memCe1N && memCe2;
      automatic logic rdAct = sel && !memOeN && memWeN;
      automatic logic wrWin = sel && !memWeN;
      if (memDqOe)
        check(!(rdAct || holdCnt > 0), "R6 R7 bus contention with RAM output", holdCnt, 0);
      if (rdAct) begin
        rdCnt++;
        holdCnt = EXP_TURN;
      end else begin
        rdCnt = 0;
        if (holdCnt > 0) holdCnt--;
      end
      if (wrWin) begin
        if (wrLen > 0)
          check(memAddr == wrAddr && memDqOut == wrData, "R3 address/data held while WE low",
                int'(memAddr), int'(wrAddr));
        check(memDqOe && memOeN, "R4 driver on and OE high during write",
              int'({memDqOe, memOeN}), 3);
        wrLen++;
        wrAddr = memAddr;
        wrData = memDqOut;
      end else if (wrLen > 0) begin
        check(wrLen == EXP_WP, "R4 write pulse width", wrLen, EXP_WP);
        check(memDqOe, "R4 data driven after WE rises", int'(memDqOe), 1);
        ram[wrAddr] = wrData;
        wrLen = 0;
      end
      memDqIn = (rdAct && rdCnt >= EXP_AA) ? ram[memAddr] : ~ram[memAddr];
    end
  end

  task automatic issue(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    checkStandby("R1 standby pins while ready");
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R2 ready low after acceptance", int'(reqReady), 0);
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    issue(1'b1, a, d);
    shadow[a] = d;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a);
    int edges;
    issue(1'b0, a, '0);
    edges = 0;
    while (!rdValid && edges < 50) begin
      @(negedge clk);
      edges++;
    end
    check(edges == EXP_AA, "R5 read valid latency", edges, EXP_AA);
    check(rdData == shadow[a], "R8 read data", int'(rdData), int'(shadow[a]));
    @(negedge clk);
    check(!rdValid, "R5 rdValid single cycle", int'(rdValid), 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R5 run did not complete actual=0 expected=1");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]    = '0;
      shadow[i] = '0;
    end
    repeat (4) @(negedge clk);
    checkStandby("R1 pins during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkStandby("R1 pins after reset");
    check(reqReady && !rdValid, "R1 ready high, rdValid low after reset",
          int'({reqReady, rdValid}), 2);

    // R2: request fields change while reqValid is low and must be ignored
    for (int i = 0; i < 10; i++) begin
      reqWrite = i[0];
      reqAddr  = ADDR_W'(i * 7);
      reqWdata = DATA_W'(i * 29);
      @(negedge clk);
      checkStandby("R2 inputs ignored without reqValid");
    end

    // Sweep 1: ascending writes, ascending reads
    for (int a = 0; a < DEPTH; a++) doWrite(ADDR_W'(a), DATA_W'((a * 37 + 11) & 8'hFF));
    for (int a = 0; a < DEPTH; a++) doRead(ADDR_W'(a));

    // Sweep 2: descending writes with inverted pattern, reads interleaved
    for (int a = DEPTH - 1; a >= 0; a--) begin
      doWrite(ADDR_W'(a), DATA_W'(~((a * 53 + 3) & 8'hFF)));
      doRead(ADDR_W'(a));
    end

    // Sweep 3: pseudo-random mix of reads and writes
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) doWrite(lfsr[ADDR_W:1], lfsr[15:8]);
      else         doRead(lfsr[ADDR_W:1]);
    end

    repeat (20) @(negedge clk);
    checkStandby("R1 standby at end");
    finishRun();
  end

endmodule